// File: doc/BRIEF.md
# Compressed Instruction Length-Mode Tracker

This block is a small registered state machine for an instruction fetch/decode front end. It looks at each 16-bit parcel that the front end accepts. From a few marker bits it works out how long the next instruction is and which decode mode applies to it. It moves between plain 32-bit instructions and two compressed modes: a 10-bit form and a 16-bit form. One extra state lets exactly one 32-bit instruction through and then falls back to 16-bit compressed mode without any further marker.

The decision uses only three things: whether the parcel's leading five bits match a configurable escape opcode, the first parcel bit (M) and the last parcel bit (N). Alongside the length and mode, the block registers a class code for the parcel it just accepted. A later pipeline stage uses that code to pick a sub-decoder. Nothing from the later decode stage feeds back into this block.

Top module: `clt_mode_tracker`

## Requirements
- R1: After reset the mode is STD (code 0), the length is 32 and the class is NONE (code 0). Mode codes: STD=0, C10=1, C16=2, ONCE (one standard instruction, then back to 16-bit) =3.
- R2: In STD, an accepted parcel whose bits 0..4 (parcel_i[15:11]) equal ESC_OP moves the tracker to C10 with length 16. Any other parcel leaves it in STD with length 32.
- R3: In C10, an accepted parcel with N=0 (parcel_i[0]) moves the tracker to STD with length 32. With N=1 it moves to C16 with length 16.
- R4: In C16, an accepted parcel with N=1 keeps the tracker in C16 with length 16, whatever M is.
- R5: In C16, an accepted parcel with N=0 gives length 32. The mode becomes ONCE when M (bit 0, parcel_i[15]) is 1, and STD when M is 0.
- R6: In ONCE, any accepted parcel, including one that matches the escape opcode, returns the tracker to C16 with length 16.
- R7: State changes only in a cycle where parcel_valid_i and parcel_accept_i are both high. In every other cycle the mode, length and class outputs keep their values.
- R8: Class codes are NONE=0, C10=1, C16_IMM=2 and C16_REG=3. On each accepted parcel the class is registered as follows: C10 if the mode was C10; C16_IMM if the mode was C16 with M=1 and N=1; C16_REG if the mode was C16 in any other case; NONE if the mode was STD or ONCE.
- R9: The length output is always 16 or 32. It is 16 exactly when the mode is C10 or C16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| parcel_valid_i | input | 1 | A parcel is presented |
| parcel_accept_i | input | 1 | The front end consumes the presented parcel |
| parcel_i | input | 16 | Parcel bits; parcel_i[15] is bit 0 (M) and parcel_i[0] is bit 15 (N) |
| next_len_o | output | 6 | Length of the next instruction, 16 or 32 |
| next_mode_o | output | 2 | Decode mode of the next instruction |
| dec_class_o | output | 2 | Sub-decoder class of the last accepted parcel |

## Verification
The bench sends an escape-valued parcel while the tracker is in the one-shot state. A design that still checks the escape opcode there would jump to C10 instead of returning to C16. It drives 16-bit parcels with N=0 and each value of M; mixing up M and N, or swapping the two target modes, shows up as the wrong mode code. It holds an escape parcel with only one of valid and accept high. A tracker that advances on valid alone would leave STD too early. It also walks through every class code, so a class taken from the new mode rather than the old one gives the wrong value.

// File: rtl/clt_pkg.sv
`timescale 1ns/1ps
package clt_pkg;
    localparam int PARCEL_W = 16;
    localparam int OPC_W    = 5;
    localparam int LEN_W    = 6;

    typedef enum logic [1:0] {
        MODE_STD  = 2'd0,
        MODE_C10  = 2'd1,
        MODE_C16  = 2'd2,
        MODE_ONCE = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_C10     = 2'd1,
        CLS_C16_IMM = 2'd2,
        CLS_C16_REG = 2'd3
    } cls_e;

    typedef struct packed {
        mode_e            mode;
        logic [LEN_W-1:0] len;
        cls_e             cls;
    } trk_state_t;

    function automatic logic [LEN_W-1:0] len_of(input mode_e m);
        return (m == MODE_C10 || m == MODE_C16) ? LEN_W'(16) : LEN_W'(32);
    endfunction
endpackage

// File: rtl/clt_fields.sv
`timescale 1ns/1ps
module clt_fields
    import clt_pkg::*;
#(
    parameter logic [OPC_W-1:0] ESC_OP = '0
) (
    input  logic [PARCEL_W-1:0] parcel_i,
    output logic                esc_hit_o,
    output logic                m_bit_o,
    output logic                n_bit_o
);
    // MSB-first numbering: bit 0 sits at the top of the vector
    localparam int TOP = PARCEL_W - 1;

    always_comb begin
        esc_hit_o = (parcel_i[TOP -: OPC_W] == ESC_OP);
        m_bit_o   = parcel_i[TOP];
        n_bit_o   = parcel_i[0];
    end
endmodule

// File: rtl/clt_next_mode.sv
`timescale 1ns/1ps
module clt_next_mode
    import clt_pkg::*;
(
    input  mode_e cur_i,
    input  logic  esc_hit_i,
    input  logic  m_bit_i,
    input  logic  n_bit_i,
    output mode_e nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            MODE_STD:  nxt_o = esc_hit_i ? MODE_C10 : MODE_STD;
            MODE_C10:  nxt_o = n_bit_i ? MODE_C16 : MODE_STD;
            MODE_C16: begin
                if (n_bit_i)      nxt_o = MODE_C16;
                else if (m_bit_i) nxt_o = MODE_ONCE;
                else              nxt_o = MODE_STD;
            end
            MODE_ONCE: nxt_o = MODE_C16;
            default:   nxt_o = MODE_STD;
        endcase
    end
endmodule

// File: rtl/clt_class.sv
`timescale 1ns/1ps
module clt_class
    import clt_pkg::*;
(
    input  mode_e cur_i,
    input  logic  m_bit_i,
    input  logic  n_bit_i,
    output cls_e  cls_o
);
    always_comb begin
        unique case (cur_i)
            MODE_C10: cls_o = CLS_C10;
            MODE_C16: cls_o = (m_bit_i && n_bit_i) ? CLS_C16_IMM : CLS_C16_REG;
            default:  cls_o = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/clt_mode_tracker.sv
`timescale 1ns/1ps
module clt_mode_tracker
    import clt_pkg::*;
#(
    parameter logic [OPC_W-1:0] ESC_OP = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                parcel_valid_i,
    input  logic                parcel_accept_i,
    input  logic [PARCEL_W-1:0] parcel_i,
    output logic [LEN_W-1:0]    next_len_o,
    output logic [1:0]          next_mode_o,
    output logic [1:0]          dec_class_o
);
    trk_state_t state_d, state_q;
    logic       esc_hit, m_bit, n_bit, fire;
    mode_e      mode_nxt;
    cls_e       cls_nxt;

    clt_fields #(.ESC_OP(ESC_OP)) u_fields (
        .parcel_i  (parcel_i),
        .esc_hit_o (esc_hit),
        .m_bit_o   (m_bit),
        .n_bit_o   (n_bit)
    );

    clt_next_mode u_next (
        .cur_i     (state_q.mode),
        .esc_hit_i (esc_hit),
        .m_bit_i   (m_bit),
        .n_bit_i   (n_bit),
        .nxt_o     (mode_nxt)
    );

    clt_class u_class (
        .cur_i   (state_q.mode),
        .m_bit_i (m_bit),
        .n_bit_i (n_bit),
        .cls_o   (cls_nxt)
    );

    assign fire = parcel_valid_i && parcel_accept_i;

    always_comb begin
        state_d = state_q;
        if (fire) begin
            state_d.mode = mode_nxt;
            state_d.len  = len_of(mode_nxt);
            state_d.cls  = cls_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.mode <= MODE_STD;
            state_q.len  <= LEN_W'(32);
            state_q.cls  <= CLS_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    assign next_len_o  = state_q.len;
    assign next_mode_o = state_q.mode;
    assign dec_class_o = state_q.cls;
endmodule

// File: rtl/clt_mode_tracker_chk.sv
`timescale 1ns/1ps
module clt_mode_tracker_chk
    import clt_pkg::*;
#(
    parameter logic [OPC_W-1:0] ESC_OP = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                parcel_valid_i,
    input logic                parcel_accept_i,
    input logic [PARCEL_W-1:0] parcel_i,
    input logic [LEN_W-1:0]    next_len_o,
    input logic [1:0]          next_mode_o,
    input logic [1:0]          dec_class_o
);
    logic acc;
    assign acc = parcel_valid_i && parcel_accept_i;

    // R9
    len_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next_len_o == 6'd16) == (next_mode_o == 2'd1 || next_mode_o == 2'd2));

    // R9
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next_len_o == 6'd16) || (next_len_o == 6'd32));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(next_mode_o) && $stable(next_len_o) && $stable(dec_class_o)));

    // R2
    std_esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && next_mode_o == 2'd0 && parcel_i[15:11] == ESC_OP) |=> next_mode_o == 2'd1);

    // R4
    c16_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && next_mode_o == 2'd2 && parcel_i[0]) |=> next_mode_o == 2'd2);

    // R6
    once_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && next_mode_o == 2'd3) |=> next_mode_o == 2'd2);

    // R8
    cls_c10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && next_mode_o == 2'd1) |=> dec_class_o == 2'd1);
endmodule

bind clt_mode_tracker clt_mode_tracker_chk #(.ESC_OP(ESC_OP)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .parcel_valid_i  (parcel_valid_i),
    .parcel_accept_i (parcel_accept_i),
    .parcel_i        (parcel_i),
    .next_len_o      (next_len_o),
    .next_mode_o     (next_mode_o),
    .dec_class_o     (dec_class_o)
);

// File: tb/clt_mode_tracker_test.sv
`timescale 1ns/1ps
module clt_mode_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic        acc = 1'b0;
    logic [15:0] parcel = 16'h0000;
    logic [5:0]  len;
    logic [1:0]  mode;
    logic [1:0]  cls;
    int checks = 0;
    int errors = 0;

    localparam logic [1:0] STD = 2'd0, C10 = 2'd1, C16 = 2'd2, ONCE = 2'd3;
    localparam logic [1:0] NONE = 2'd0, K10 = 2'd1, KIMM = 2'd2, KREG = 2'd3;

    always #4 clk = ~clk;

    clt_mode_tracker #(.ESC_OP(5'b00000)) uut (
        .clk (clk), .rst_n (rst_n),
        .parcel_valid_i (vld), .parcel_accept_i (acc), .parcel_i (parcel),
        .next_len_o (len), .next_mode_o (mode), .dec_class_o (cls)
    );

    task automatic expect_st(input string tag, input logic [1:0] em,
                             input logic [5:0] el, input logic [1:0] ec);
        checks++;
        if (mode !== em || len !== el || cls !== ec) begin
            errors++;
            $display("FAIL %s: mode=%0d len=%0d cls=%0d expected mode=%0d len=%0d cls=%0d",
                     tag, mode, len, cls, em, el, ec);
        end
    endtask

    task automatic send(input logic [15:0] p, input logic v, input logic a);
        @(negedge clk);
        vld = v; acc = a; parcel = p;
        @(negedge clk);
        vld = 1'b0; acc = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        expect_st("R1 reset", STD, 6'd32, NONE);
    endtask

    task automatic t_std();
        send(16'h7A42, 1, 1);
        expect_st("R2 non-escape stays", STD, 6'd32, NONE);
        send(16'h0015, 1, 1);
        expect_st("R2 escape to C10", C10, 6'd16, NONE);
    endtask

    task automatic t_c10();
        send(16'h1234, 1, 1);
        expect_st("R3 C10 N=0 to STD, R8 class", STD, 6'd32, K10);
        send(16'h0000, 1, 1);
        expect_st("R2 escape again", C10, 6'd16, NONE);
        send(16'h0235, 1, 1);
        expect_st("R3 C10 N=1 to C16", C16, 6'd16, K10);
    endtask

    task automatic t_c16();
        send(16'h8003, 1, 1);
        expect_st("R4 M=1 N=1, R8 imm", C16, 6'd16, KIMM);
        send(16'h0041, 1, 1);
        expect_st("R4 M=0 N=1, R8 reg", C16, 6'd16, KREG);
        send(16'h8002, 1, 1);
        expect_st("R5 M=1 N=0 to ONCE", ONCE, 6'd32, KREG);
        send(16'h0000, 1, 1);
        expect_st("R6 ONCE ignores escape", C16, 6'd16, NONE);
        send(16'h4000, 1, 1);
        expect_st("R5 M=0 N=0 to STD", STD, 6'd32, KREG);
    endtask

    task automatic t_hold();
        send(16'h0000, 1, 0);
        expect_st("R7 valid only", STD, 6'd32, KREG);
        send(16'h0000, 0, 1);
        expect_st("R7 accept only", STD, 6'd32, KREG);
        send(16'h0000, 1, 1);
        expect_st("R7 both high advances", C10, 6'd16, NONE);
        send(16'h0001, 1, 0);
        expect_st("R7 hold in C10", C10, 6'd16, NONE);
    endtask

    initial begin
        #160000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_std();
        t_c10();
        t_c16();
        t_hold();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule